// File: doc/BRIEF.md
# Real-Time Clock Register Bank

This block is the register bank of a real-time clock, reached through an index port and a data port. A write on the index port selects one of fourteen registers, numbered 0 to 13. A write or read on the data port then reaches the selected register. Registers 0 to 9 hold time and calendar bytes. They are plain storage that software loads and reads back; the block never advances them. Register 10 is a status byte with a fixed time-base and rate field and a flag bit that flips on every read. Register 11 is a control byte. Its bit 6 enables a periodic interrupt pulse, and its binary and 24-hour bits are fixed. Registers 12 and 13 always read as zero.

Writes that break the rules are dropped, and a sticky error flag is set. Only one access takes effect per cycle. The periodic interrupt is a single-cycle pulse that repeats every `PERIOD` clock cycles for as long as the enable bit is set.

Top module: `rtc_regfile`

## Requirements
- R1: An index write with a value from 0 to 13 selects that register. A value above 13 is dropped, the previous index is kept, and errFlag is set.
- R2: Time bytes 0 to 9 read back the last value written to them. After reset, bytes 6, 7 and 8 (weekday, day of month and month, all counted from one) hold 0x01, and the other bytes hold 0x00.
- R3: Register 10 resets to 0x26, which is a time-base field of 0x2 in bits 6:4 and a rate field of 0x6 in bits 3:0. Every read flips bit 7, stores the result and returns the flipped value.
- R4: A write to register 10 is accepted only when the value is exactly 0x26. Any other value is dropped and sets errFlag.
- R5: Register 11 resets to 0x46. In that value, bit 6 is the interrupt enable, bit 2 is binary mode and bit 1 is 24-hour mode. A write is accepted only when its bits other than bit 6 and bit 3 (square-wave enable) equal 0x06. Any other write is dropped and sets errFlag. A read returns the stored value.
- R6: Registers 12 and 13 read as 0x00. Any write to them is dropped and sets errFlag.
- R7: While register 11 bit 6 is set, periodicIrq pulses high for one cycle every PERIOD cycles. The first pulse comes PERIOD cycles after the edge that sets the bit. Writing 1 to the bit while it is already set keeps the phase. Clearing the bit stops the pulses and resets the phase.
- R8: errFlag is sticky. Only reset clears it.
- R9: A data read loads rdData at the clock edge. rdData then holds that value until the next data read, and it is 0x00 after reset.
- R10: When several strobes are high in the same cycle, only one takes effect. An index write wins over a data write, and a data write wins over a data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| idxWe | input | 1 | Index port write strobe |
| dataWe | input | 1 | Data port write strobe |
| dataRe | input | 1 | Data port read strobe |
| wrData | input | 8 | Write value for the index or data port |
| rdData | output | 8 | Registered read value |
| periodicIrq | output | 1 | Single-cycle periodic interrupt pulse |
| errFlag | output | 1 | Sticky flag for dropped writes |

## Verification
Index, register and error-flag updates take effect at the clock edge that samples the strobe. A read shows on rdData after that same edge. The periodic pulse is registered, and it rises exactly PERIOD edges after the edge that sets the enable.

The bench drives each access half a cycle before an edge and keeps a cycle-by-cycle reference model that advances at that edge. It compares rdData, errFlag and periodicIrq at the following falling edge. Every cycle therefore checks the pulse timing along with the access results.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned NUM_TIME = 10;
  localparam int unsigned IDX_A    = 10;
  localparam int unsigned IDX_B    = 11;
  localparam int unsigned IDX_MAX  = 13;

  localparam logic [7:0] A_FIXED    = 8'h26;
  localparam logic [7:0] B_RESET    = 8'h46;
  localparam logic [7:0] B_FREE     = 8'h48;
  localparam logic [7:0] B_FIXED    = 8'h06;
  localparam logic [7:0] FLIP_MASK  = 8'h80;
  localparam int unsigned PIE_POS   = 6;

  typedef struct packed {
    logic idxLoad;
    logic timeLoad;
    logic aLoad;
    logic bLoad;
    logic aRead;
    logic rdLoad;
    logic errSet;
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic             idxWe,
  input  logic             dataWe,
  input  logic             dataRe,
  input  logic [7:0]       wrData,
  input  logic [IDX_W-1:0] curIdx,
  output rtcStrobe_t       strb
);
  logic idxOk;
  logic bOk;

  assign idxOk = (wrData <= 8'(IDX_MAX));
  assign bOk   = ((wrData & ~B_FREE) == B_FIXED);

  always_comb begin
    strb = '0;
    if (idxWe) begin
      if (idxOk) strb.idxLoad = 1'b1;
      else       strb.errSet  = 1'b1;
    end else if (dataWe) begin
      if (32'(curIdx) < NUM_TIME) begin
        strb.timeLoad = 1'b1;
      end else if (32'(curIdx) == IDX_A) begin
        if (wrData == A_FIXED) strb.aLoad  = 1'b1;
        else                   strb.errSet = 1'b1;
      end else if (32'(curIdx) == IDX_B) begin
        if (bOk) strb.bLoad  = 1'b1;
        else     strb.errSet = 1'b1;
      end else begin
        strb.errSet = 1'b1;
      end
    end else if (dataRe) begin
      strb.rdLoad = 1'b1;
      strb.aRead  = (32'(curIdx) == IDX_A);
    end
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int unsigned PERIOD = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  rtcStrobe_t       strb,
  input  logic [7:0]       wrData,
  output logic [IDX_W-1:0] curIdx,
  output logic [7:0]       rdData,
  output logic             errFlag,
  output logic             periodicIrq,
  output logic             pieEn
);
  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);

  logic [7:0]       timeReg [NUM_TIME];
  logic [7:0]       regA;
  logic [7:0]       regB;
  logic [7:0]       rdNext;
  logic [CNT_W-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             curIdx <= '0;
    else if (strb.idxLoad) curIdx <= wrData[IDX_W-1:0];
  end

  for (genvar g = 0; g < NUM_TIME; g++) begin : g_time
    localparam logic [7:0] RST_VAL = (g >= 6 && g <= 8) ? 8'h01 : 8'h00;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        timeReg[g] <= RST_VAL;
      else if (strb.timeLoad && (32'(curIdx) == g))
        timeReg[g] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           regA <= A_FIXED;
    else if (strb.aLoad) regA <= wrData;
    else if (strb.aRead) regA <= regA ^ FLIP_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           regB <= B_RESET;
    else if (strb.bLoad) regB <= wrData;
  end

  assign pieEn = regB[PIE_POS];

  always_comb begin
    if (32'(curIdx) < NUM_TIME)    rdNext = timeReg[curIdx];
    else if (32'(curIdx) == IDX_A) rdNext = regA ^ FLIP_MASK;
    else if (32'(curIdx) == IDX_B) rdNext = regB;
    else                           rdNext = 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= 8'h00;
    else if (strb.rdLoad) rdData <= rdNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            errFlag <= 1'b0;
    else if (strb.errSet) errFlag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt     <= '0;
      periodicIrq <= 1'b0;
    end else if (!pieEn) begin
      tickCnt     <= '0;
      periodicIrq <= 1'b0;
    end else if (tickCnt == CNT_LAST) begin
      tickCnt     <= '0;
      periodicIrq <= 1'b1;
    end else begin
      tickCnt     <= tickCnt + 1'b1;
      periodicIrq <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int unsigned PERIOD = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       idxWe,
  input  logic       dataWe,
  input  logic       dataRe,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       periodicIrq,
  output logic       errFlag
);
  rtcStrobe_t       strb;
  logic [IDX_W-1:0] curIdx;
  logic             pieEn;

  rtc_ctrl ctrl_i (
    .idxWe (idxWe),
    .dataWe(dataWe),
    .dataRe(dataRe),
    .wrData(wrData),
    .curIdx(curIdx),
    .strb  (strb)
  );

  rtc_datapath #(.PERIOD(PERIOD)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .curIdx     (curIdx),
    .rdData     (rdData),
    .errFlag    (errFlag),
    .periodicIrq(periodicIrq),
    .pieEn      (pieEn)
  );
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk (
  input logic       clk,
  input logic       rstN,
  input logic       idxWe,
  input logic       dataRe,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       periodicIrq,
  input logic       errFlag,
  input logic       pieEn,
  input logic [3:0] curIdx
);
  a_r1_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    curIdx <= 4'd13);

  a_r1_bad_idx_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (idxWe && wrData > 8'd13) |=> ($stable(curIdx) && errFlag));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  a_r9_rd_holds: assert property (@(posedge clk) disable iff (!rstN)
    !dataRe |=> $stable(rdData));

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    !pieEn |=> !periodicIrq);

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    periodicIrq |=> !periodicIrq);
endmodule

bind rtc_regfile rtc_regfile_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .idxWe      (idxWe),
  .dataRe     (dataRe),
  .wrData     (wrData),
  .rdData     (rdData),
  .periodicIrq(periodicIrq),
  .errFlag    (errFlag),
  .pieEn      (pieEn),
  .curIdx     (curIdx)
);

// File: tb/rtc_regfile_tb.sv
`timescale 1ns/1ps
module rtc_regfile_tb_top;
  localparam int PER = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       idxWe = 1'b0, dataWe = 1'b0, dataRe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       periodicIrq, errFlag;

  always #2.5 clk = ~clk;

  rtc_regfile #(.PERIOD(PER)) dut_i (
    .clk(clk), .rstN(rstN), .idxWe(idxWe), .dataWe(dataWe), .dataRe(dataRe),
    .wrData(wrData), .rdData(rdData), .periodicIrq(periodicIrq), .errFlag(errFlag)
  );

  int nVec = 0, nFail = 0;
  logic [3:0] mIdx;
  logic [7:0] mTime [10];
  logic [7:0] mA, mB, mRd;
  logic       mErr, mIrq;
  int         mCnt;

  task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mIdx = 0; mA = 8'h26; mB = 8'h46; mRd = 0; mErr = 0; mIrq = 0; mCnt = 0;
    for (int i = 0; i < 10; i++) mTime[i] = (i >= 6 && i <= 8) ? 8'h01 : 8'h00;
  endtask

  task automatic modelEdge(input logic iw, input logic dw, input logic dr, input logic [7:0] d);
    // R7: pulse timing from the enable as it stood before this edge
    if (!mB[6]) begin mCnt = 0; mIrq = 0; end
    else if (mCnt == PER - 1) begin mCnt = 0; mIrq = 1; end
    else begin mCnt++; mIrq = 0; end
    // R10: index write > data write > data read
    if (iw) begin
      if (d <= 8'd13) mIdx = d[3:0]; else mErr = 1;
    end else if (dw) begin
      if (mIdx < 10) mTime[mIdx] = d;
      else if (mIdx == 10) begin if (d == 8'h26) mA = d; else mErr = 1; end
      else if (mIdx == 11) begin if ((d & 8'hB7) == 8'h06) mB = d; else mErr = 1; end
      else mErr = 1;
    end else if (dr) begin
      if (mIdx < 10) mRd = mTime[mIdx];
      else if (mIdx == 10) begin mA = mA ^ 8'h80; mRd = mA; end
      else if (mIdx == 11) mRd = mB;
      else mRd = 8'h00;
    end
  endtask

  task automatic step(input logic iw, input logic dw, input logic dr,
                      input logic [7:0] d, input string req);
    idxWe = iw; dataWe = dw; dataRe = dr; wrData = d;
    @(posedge clk);
    modelEdge(iw, dw, dr, d);
    @(negedge clk);
    idxWe = 0; dataWe = 0; dataRe = 0;
    cmp(req, rdData, mRd);
    cmp("R8 errFlag", 8'(errFlag), 8'(mErr));
    cmp("R7 periodicIrq", 8'(periodicIrq), 8'(mIrq));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, "R7 idle");
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    repeat (3) @(negedge clk);
    modelReset();
    cmp("R9 reset rdData", rdData, 8'h00);
    cmp("R8 reset errFlag", 8'(errFlag), 8'h00);
    cmp("R7 reset irq", 8'(periodicIrq), 8'h00);
    rstN = 1;
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got hung expected done");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    doReset();
    // R2 R3 R5 R6: reset contents of every register
    for (int r = 0; r < 14; r++) begin
      step(1, 0, 0, 8'(r), "R1 select");
      step(0, 0, 1, 8'h00, r < 10 ? "R2 reset byte" : (r == 10 ? "R3 first read" :
           (r == 11 ? "R5 reset B" : "R6 C/D zero")));
    end
    step(1, 0, 0, 8'd10, "R1 select A");
    step(0, 0, 1, 8'h00, "R3 toggle 1");
    step(0, 0, 1, 8'h00, "R3 toggle 2");
    // R7: pulses from reset, disable, re-enable, rewrite keeps phase
    idle(40);
    step(1, 0, 0, 8'd11, "R1 select B");
    step(0, 1, 0, 8'h06, "R7 disable");
    idle(40);
    step(0, 1, 0, 8'h4E, "R7 enable with square wave bit");
    idle(21);
    step(0, 1, 0, 8'h46, "R7 rewrite enable");
    idle(25);
    step(0, 0, 1, 8'h00, "R5 read B");
    // R2: store and read back
    step(1, 0, 0, 8'd3, "R1 select 3");
    step(0, 1, 0, 8'h5A, "R2 write");
    step(0, 0, 1, 8'h00, "R2 readback");
    // R10: priority
    step(1, 1, 1, 8'd2, "R10 idx wins");
    step(0, 1, 1, 8'h77, "R10 write wins over read");
    step(0, 0, 1, 8'h00, "R10 readback");
    // R4 R5 R6 R1: rejected writes
    step(1, 0, 0, 8'd10, "R1 select A");
    step(0, 1, 0, 8'h27, "R4 bad A write");
    step(0, 0, 1, 8'h00, "R4 A kept");
    step(0, 1, 0, 8'h26, "R4 good A write");
    step(0, 0, 1, 8'h00, "R4 A read");
    step(1, 0, 0, 8'd11, "R1 select B");
    step(0, 1, 0, 8'h40, "R5 bad B write");
    step(0, 0, 1, 8'h00, "R5 B kept");
    step(1, 0, 0, 8'd12, "R1 select C");
    step(0, 1, 0, 8'h11, "R6 write C");
    step(0, 0, 1, 8'h00, "R6 C zero");
    step(1, 0, 0, 8'h0E, "R1 index 14 dropped");
    step(0, 0, 1, 8'h00, "R1 index kept");
    step(1, 0, 0, 8'hFF, "R1 index FF dropped");
    idle(5);
    // random phase
    doReset();
    for (int i = 0; i < 600; i++) begin
      logic [7:0] d;
      logic iw, dw, dr;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2: d = 8'($urandom_range(0, 15));
        3: d = 8'h26;
        4: d = 8'h46;
        5: d = 8'h06;
        6: d = 8'h4E;
        default: d = 8'($urandom);
      endcase
      iw = ($urandom_range(0, 3) == 0);
      dw = ($urandom_range(0, 3) == 0);
      dr = ($urandom_range(0, 2) == 0);
      step(iw, dw, dr, d, "R9 random read");
    end
    finishRun();
  end
endmodule